// File: doc/BRIEF.md
# Edge-Triggered Interrupt Request Controller

This block gathers eight interrupt conditions into one active-low interrupt pin. Each condition arrives as a level. The controller watches each level for its onset, which is a low-to-high transition. On an onset it latches a request bit that software can read. Software acknowledges a request by writing a zero into the matching bit of a clear word.

A per-source mask register decides which latched requests may pull the pin low. A masked source is still recorded in the request register, so software can poll it without taking an interrupt.

The pin follows edges, not levels. A condition that stays asserted produces exactly one request. Acknowledging it releases the pin at once. The request bit keeps reporting the condition until the level falls. Only a fresh onset can drive the pin low again.

Top module: `irq_edge_ctrl`

## Requirements
- R1: After a synchronous reset, the request register reads all zeros. The pin is high (inactive). The mask register reads all ones, which means every source is masked.
- R2: A rising transition on source i sets request bit i at the next clock edge. Source i always maps to bit i.
- R3: Mask bit i = 1 blocks source i from the pin only; request bit i still latches. A mask write takes effect at the edge that stores it. Unmasking a source with an unacknowledged event drives the pin low at that edge.
- R4: A clear write with bit i = 0, while source i is low, resets request bit i at the next edge. It also withdraws that source's contribution to the pin.
- R5: A clear write with bit i = 0, while source i is still high, withdraws the pin contribution but leaves request bit i set. The bit then drops at the edge after the source goes low.
- R6: A clear write with bit i = 1 leaves request bit i and its pending event unchanged.
- R7: A source held high produces only one event. Once it is acknowledged, the pin stays high for as long as the level stays high.
- R8: A new rising transition after an acknowledgement sets the event again and drives the pin low.
- R9: If a clear of bit i and a rising transition on source i happen in the same cycle, the transition wins. The bit stays set and the event stays pending.
- R10: The pin is registered and active low. After each edge it is low exactly when some source has an unmasked, unacknowledged event.
- R11: A request that has not been acknowledged stays set after its source falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Level condition per source |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wd_i | input | NUM_SRC | Mask write data (1 = masked) |
| mask_o | output | NUM_SRC | Current mask register |
| clr_we_i | input | 1 | Clear word write strobe |
| clr_wd_i | input | NUM_SRC | Clear data (0 = acknowledge bit) |
| req_o | output | NUM_SRC | Request register |
| irq_n_o | output | 1 | Interrupt pin, active low |

## Verification
Two pairs of events can land in the same cycle and must be checked together.

The first pair is a clear of bit i and a new onset on source i. The bench forces this by raising the source in the same cycle as the clear strobe. It expects the bit to stay set and the pin to stay low.

The second pair is a mask write and a still-pending event. The bench unmasks a source that has latched but is masked, and expects the pin to fall at that edge.

A randomized phase then mixes onsets, clears and mask writes in every combination. A behavioural model in the bench judges each edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // Per-source state: latched request and unacknowledged edge event
  typedef struct packed {
    logic req;
    logic pend;
  } irq_cell_t;

  localparam int unsigned IRQ_SRC_DEFAULT = 8;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/irq_req_cell.sv
module irq_req_cell
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rise_i,
  input  logic lvl_i,
  input  logic ack_i,
  output logic req_o,
  output logic pend_d_o
);
  irq_cell_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (rise_i)     st_d.pend = 1'b1;   // onset beats a same-cycle clear
    else if (ack_i) st_d.pend = 1'b0;
    st_d.req = st_d.pend | (st_q.req & lvl_i);
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= st_d;
  end

  assign req_o    = st_q.req;
  assign pend_d_o = st_d.pend;
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pend_d_i,
  input  logic [W-1:0] mask_d_i,
  output logic         irq_n_o
);
  logic irq_n_q;

  always_ff @(posedge clk) begin
    if (rst) irq_n_q <= 1'b1;
    else     irq_n_q <= ~|(pend_d_i & ~mask_d_i);
  end

  assign irq_n_o = irq_n_q;
endmodule

// File: rtl/irq_edge_ctrl.sv
module irq_edge_ctrl #(
  parameter int unsigned NUM_SRC = irq_pkg::IRQ_SRC_DEFAULT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               mask_we_i,
  input  logic [NUM_SRC-1:0] mask_wd_i,
  output logic [NUM_SRC-1:0] mask_o,
  input  logic               clr_we_i,
  input  logic [NUM_SRC-1:0] clr_wd_i,
  output logic [NUM_SRC-1:0] req_o,
  output logic               irq_n_o
);
  localparam logic [NUM_SRC-1:0] MASK_RST = '1;

  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] ack;
  logic [NUM_SRC-1:0] pend_d;
  logic [NUM_SRC-1:0] mask_q, mask_d;

  assign ack    = {NUM_SRC{clr_we_i}} & ~clr_wd_i;
  assign mask_d = mask_we_i ? mask_wd_i : mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= MASK_RST;
    else     mask_q <= mask_d;
  end

  irq_edge_det #(.W(NUM_SRC)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (src_i),
    .rise_o (rise)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
    irq_req_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .rise_i   (rise[g]),
      .lvl_i    (src_i[g]),
      .ack_i    (ack[g]),
      .req_o    (req_o[g]),
      .pend_d_o (pend_d[g])
    );
  end

  irq_pin_drv #(.W(NUM_SRC)) u_pin (
    .clk      (clk),
    .rst      (rst),
    .pend_d_i (pend_d),
    .mask_d_i (mask_d),
    .irq_n_o  (irq_n_o)
  );

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_edge_ctrl_chk.sv
module irq_edge_ctrl_chk #(
  parameter int unsigned NUM_SRC = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] src_i,
  input logic               mask_we_i,
  input logic [NUM_SRC-1:0] mask_wd_i,
  input logic [NUM_SRC-1:0] mask_o,
  input logic               clr_we_i,
  input logic [NUM_SRC-1:0] clr_wd_i,
  input logic [NUM_SRC-1:0] req_o,
  input logic               irq_n_o
);
  logic [NUM_SRC-1:0] prev;
  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= src_i;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (irq_n_o && req_o == '0 && mask_o == '1));

  // R10
  pin_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_n_o |-> (|(req_o & ~mask_o)));

  // R7
  pin_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n_o) |-> $past((|(src_i & ~prev)) || mask_we_i));

  // R3
  mask_store_chk: assert property (@(posedge clk) disable iff (rst)
    mask_we_i |=> mask_o == $past(mask_wd_i));

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    // R2
    onset_latch_chk: assert property (@(posedge clk) disable iff (rst)
      (src_i[g] && !prev[g]) |=> req_o[g]);

    // R4
    clear_low_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_we_i && !clr_wd_i[g] && !src_i[g]) |=> !req_o[g]);

    // R6
    write_one_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_we_i && clr_wd_i[g] && req_o[g] && src_i[g]) |=> req_o[g]);
  end
endmodule

bind irq_edge_ctrl irq_edge_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .src_i     (src_i),
  .mask_we_i (mask_we_i),
  .mask_wd_i (mask_wd_i),
  .mask_o    (mask_o),
  .clr_we_i  (clr_we_i),
  .clr_wd_i  (clr_wd_i),
  .req_o     (req_o),
  .irq_n_o   (irq_n_o)
);

// File: tb/test_irq_edge_ctrl.sv
`timescale 1ns/1ps
module test_irq_edge_ctrl;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] src = '0;
  logic         mask_we = 1'b0;
  logic [N-1:0] mask_wd = '0;
  logic         clr_we = 1'b0;
  logic [N-1:0] clr_wd = '1;
  logic [N-1:0] mask_o, req_o;
  logic         irq_n;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  irq_edge_ctrl #(.NUM_SRC(N)) i_irq_edge_ctrl (
    .clk(clk), .rst(rst), .src_i(src),
    .mask_we_i(mask_we), .mask_wd_i(mask_wd), .mask_o(mask_o),
    .clr_we_i(clr_we), .clr_wd_i(clr_wd),
    .req_o(req_o), .irq_n_o(irq_n)
  );

  // Behavioural reference, one bit per integer slot
  int m_req[N], m_pend[N], m_prev[N], m_mask[N];
  int m_irq_n = 1;

  always begin
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_req[i] = 0; m_pend[i] = 0; m_prev[i] = 0; m_mask[i] = 1;
      end
      m_irq_n = 1;
    end else begin
      m_irq_n = 1;
      for (int i = 0; i < N; i++) begin
        if (src[i] && m_prev[i] == 0) m_pend[i] = 1;
        else if (clr_we && !clr_wd[i]) m_pend[i] = 0;
        if (m_pend[i] == 1) m_req[i] = 1;
        else if (!src[i]) m_req[i] = 0;
        m_prev[i] = src[i] ? 1 : 0;
        if (mask_we) m_mask[i] = mask_wd[i] ? 1 : 0;
        if (m_pend[i] == 1 && m_mask[i] == 0) m_irq_n = 0;
      end
    end
    #1;
    for (int i = 0; i < N; i++) begin
      total++;
      if (req_o[i] !== m_req[i][0] || mask_o[i] !== m_mask[i][0]) begin
        bad++;
        $display("FAIL R2 model bit %0d: req=%b mask=%b expected req=%0d mask=%0d",
                 i, req_o[i], mask_o[i], m_req[i], m_mask[i]);
      end
    end
    total++;
    if (irq_n !== m_irq_n[0]) begin
      bad++;
      $display("FAIL R10 model pin: actual=%b expected=%0d", irq_n, m_irq_n);
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr_write(logic [N-1:0] d);
    clr_we = 1'b1; clr_wd = d; cyc(); clr_we = 1'b0; clr_wd = '1;
  endtask

  task automatic mask_write(logic [N-1:0] d);
    mask_we = 1'b1; mask_wd = d; cyc(); mask_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) cyc();
    chk("R1 req", req_o, '0);
    chk("R1 pin", {7'b0, irq_n}, 8'h01);
    chk("R1 mask", mask_o, 8'hFF);
    rst = 1'b0;
    mask_write(8'h00);
    chk("R3 mask write", mask_o, 8'h00);

    src[0] = 1'b1; cyc();
    chk("R2 onset", req_o, 8'h01);
    chk("R10 pin low", {7'b0, irq_n}, 8'h00);
    clr_write(8'hFE);
    chk("R5 bit held", req_o, 8'h01);
    chk("R5 pin released", {7'b0, irq_n}, 8'h01);
    repeat (3) cyc();
    chk("R7 no retrigger", {7'b0, irq_n}, 8'h01);
    src[0] = 1'b0; cyc();
    chk("R5 bit drops", req_o, 8'h00);
    src[0] = 1'b1; cyc();
    chk("R8 re-raise req", req_o, 8'h01);
    chk("R8 re-raise pin", {7'b0, irq_n}, 8'h00);
    src[0] = 1'b0; cyc();
    chk("R11 latched", req_o, 8'h01);
    clr_write(8'hFF);
    chk("R6 write one req", req_o, 8'h01);
    chk("R6 write one pin", {7'b0, irq_n}, 8'h00);
    clr_write(8'hFE);
    chk("R4 cleared req", req_o, 8'h00);
    chk("R4 cleared pin", {7'b0, irq_n}, 8'h01);

    mask_write(8'h04);
    src[2] = 1'b1; cyc();
    chk("R3 masked latch", req_o, 8'h04);
    chk("R3 masked pin", {7'b0, irq_n}, 8'h01);
    mask_write(8'h00);
    chk("R3 unmask pin", {7'b0, irq_n}, 8'h00);
    clr_write(8'hFB);
    src[2] = 1'b0; cyc();
    chk("R5 drop after ack", req_o, 8'h00);

    src[5] = 1'b1; clr_write(8'hDF);
    chk("R9 onset wins req", req_o, 8'h20);
    chk("R9 onset wins pin", {7'b0, irq_n}, 8'h00);
    src[5] = 1'b0; clr_write(8'hDF);
    chk("R4 after collision", req_o, 8'h00);

    for (int k = 0; k < 400; k++) begin
      src = src ^ N'($urandom_range(0, 255) & $urandom_range(0, 255));
      clr_we = ($urandom_range(0, 3) == 0);
      clr_wd = N'($urandom_range(0, 255));
      mask_we = ($urandom_range(0, 7) == 0);
      mask_wd = N'($urandom_range(0, 255));
      cyc();
    end
    clr_we = 1'b0; mask_we = 1'b0;
    cyc();
    finish_run();
  end
endmodule